// File: doc/BRIEF.md
# Segment LCD Clock and Frame Generator

This block produces the timing pulses that a segment LCD driver needs. A small control register picks the internal source for the display timing. The source is either a slow subsystem clock or the main clock divided by one of three powers of two. The same register also picks a second power-of-two division, and that division turns the source into the LCD clock. A common-phase counter then steps through the commons of the chosen duty (three or four) on each LCD clock pulse. It emits a frame tick each time the phase returns to zero.

Every divided clock is a single-cycle enable pulse in the system clock domain. The two raw sources arrive as enable inputs (`main_ce`, `sub_ce`). The register can only be changed while the external voltage booster is off. A write that would push the frame rate above the allowed limit is refused. Both kinds of refused write raise their own sticky flag. Any change of the stored setting or of the duty clears every divider, so the next frame has its full length.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `com_idx` is 0, and `lcd_ce`, `frame_tick`, `lock_err` and `rate_err` are all 0.
- R2: Stored bits [3:2] select the source. Code 0 counts `sub_ce` pulses one for one. Code k (1..3) emits one source pulse per 2^(SRC_DIV_BASE+k-1) `main_ce` pulses. The source that is not selected has no effect.
- R3: Stored bits [1:0] (code c) make `lcd_ce` pulse once for every 2^(LCD_DIV_BASE+c) source pulses.
- R4: A write made while `boost_on` is 1 leaves the stored value unchanged and sets `lock_err`. `lock_err` stays 1 until reset.
- R5: While `boost_on` is 0, a write is refused if the source rate exceeds MAX_FRAME_HZ × commons × 2^(LCD_DIV_BASE+c). The source rate is SUB_HZ for code 0 and MAIN_HZ / 2^(SRC_DIV_BASE+k-1) for code k, and commons is taken from the present `duty4`. A refused write keeps the old setting and sets `rate_err`, which stays 1 until reset.
- R6: `reg_rdata` returns the stored 4-bit setting in bits [3:0], and bits [7:4] always read 0. Bits [7:4] of a write are discarded.
- R7: `com_idx` advances by one on each `lcd_ce` pulse. It wraps from 3 to 0 when `duty4` is 1 and from 2 to 0 when `duty4` is 0. `frame_tick` is high for one cycle, in the same cycle that `com_idx` shows the wrap to 0.
- R8: An accepted write that changes the stored value, or a change of `duty4`, clears all divider and phase state on that edge. Pulses still in flight are dropped, and counting restarts from zero.
- R9: `lcd_ce` is high exactly two cycles after the cycle in which the completing raw source pulse is presented. `frame_tick` follows one cycle after the `lcd_ce` pulse that ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| boost_on | input | 1 | Voltage booster running; locks the register |
| main_ce | input | 1 | Main clock enable pulse |
| sub_ce | input | 1 | Subsystem clock enable pulse |
| duty4 | input | 1 | 1 selects four commons, 0 selects three |
| lcd_ce | output | 1 | LCD clock enable pulse |
| frame_tick | output | 1 | One-cycle frame pulse |
| com_idx | output | 2 | Current common phase |
| lock_err | output | 1 | Sticky: write attempted while locked |
| rate_err | output | 1 | Sticky: write refused for frame rate |

## Verification
A restart and a pending output pulse can fall in the same cycle. A duty change or a setting change lands on the edge where an `lcd_ce` or `frame_tick` is still inside the two-stage pipeline. The bench provokes this by switching the duty in the middle of a stream of source pulses. A per-cycle model, with its pipeline flushed at that same edge, expects the pending pulse to vanish and the phase to restart at 0. Every sweep over all settings and both duties also drives both raw sources at once. This shows whether the unselected source ever leaks into the count.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

   localparam int SEL_W   = 2;
   localparam int DUTY_LO = 3;
   localparam int DUTY_HI = 4;

   typedef struct packed {
      logic [SEL_W-1:0] src_sel;
      logic [SEL_W-1:0] div_sel;
   } lcd_cfg_t;

   localparam int CFG_W = $bits(lcd_cfg_t);

   // True when the frame rate of setting c at the given duty exceeds max_hz.
   // Both sides are scaled by the total division so integers stay exact.
   function automatic logic frame_too_fast(
      input lcd_cfg_t c,
      input logic     d4,
      input longint   sub_hz,
      input longint   main_hz,
      input longint   max_hz,
      input int       src_base,
      input int       lcd_base);
      longint src;
      longint lim;
      longint commons;
      int     sh;
      sh = lcd_base + int'(c.div_sel);
      if (c.src_sel == '0) begin
         src = sub_hz;
      end else begin
         src = main_hz;
         sh  = sh + src_base + int'(c.src_sel) - 1;
      end
      commons = d4 ? longint'(DUTY_HI) : longint'(DUTY_LO);
      lim = (max_hz * commons) << sh;
      return src > lim;
   endfunction

endpackage

// File: rtl/lcd_pow2_div.sv
module lcd_pow2_div #(
   parameter int BASE  = 1,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   input  logic             in_ce,
   output logic             out_ce
);
   localparam int CW = BASE + (1 << SEL_W) - 1;

   generate
      if (BASE < 1) begin : g_bad_base
         $error("lcd_pow2_div: BASE must be at least 1");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("lcd_pow2_div: SEL_W must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   // Terminal count 2^(BASE+sel)-1; the top code wraps to all ones.
   assign lim = (CW'(1) << (BASE + int'(sel))) - CW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt    <= '0;
         out_ce <= 1'b0;
      end else begin
         out_ce <= 1'b0;
         if (in_ce) begin
            if (cnt == lim) begin
               cnt    <= '0;
               out_ce <= 1'b1;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/lcd_src_sel.sv
module lcd_src_sel #(
   parameter int SRC_DIV_BASE = 5,
   parameter int SEL_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             main_ce,
   input  logic             sub_ce,
   output logic             src_ce
);
   logic             use_sub;
   logic             main_div_ce;
   logic             sub_q;
   logic [SEL_W-1:0] main_sel;

   assign use_sub  = (src_sel == '0);
   assign main_sel = src_sel - SEL_W'(1);

   lcd_pow2_div #(
      .BASE  (SRC_DIV_BASE),
      .SEL_W (SEL_W)
   ) u_main_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .sel    (main_sel),
      .in_ce  (main_ce && !use_sub),
      .out_ce (main_div_ce)
   );

   // Register the direct path so both sources share one cycle of latency.
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sub_q <= 1'b0;
      end else begin
         sub_q <= sub_ce && use_sub;
      end
   end

   assign src_ce = use_sub ? sub_q : main_div_ce;
endmodule

// File: rtl/lcd_frame_ctr.sv
module lcd_frame_ctr #(
   parameter int DUTY_A = 3,
   parameter int DUTY_B = 4,
   parameter int IDX_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             duty_b,
   input  logic             step_ce,
   output logic [IDX_W-1:0] idx,
   output logic             tick
);
   generate
      if (DUTY_A < 2 || DUTY_B < 2) begin : g_bad_duty
         $error("lcd_frame_ctr: a duty needs at least two commons");
      end
      if ((1 << IDX_W) < DUTY_A || (1 << IDX_W) < DUTY_B) begin : g_bad_idx
         $error("lcd_frame_ctr: IDX_W too narrow for the duty");
      end
   endgenerate

   logic [IDX_W-1:0] last;
   assign last = duty_b ? IDX_W'(DUTY_B - 1) : IDX_W'(DUTY_A - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         idx  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (step_ce) begin
            if (idx == last) begin
               idx  <= '0;
               tick <= 1'b1;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg
   import lcd_timing_pkg::*;
#(
   parameter int SUB_HZ       = 32768,
   parameter int MAIN_HZ      = 5000000,
   parameter int MAX_FRAME_HZ = 128,
   parameter int SRC_DIV_BASE = 5,
   parameter int LCD_DIV_BASE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   input  logic             boost_on,
   input  logic             duty4,
   output lcd_cfg_t         cfg,
   output logic             cfg_change,
   output logic             lock_err,
   output logic             rate_err
);
   lcd_cfg_t wcfg;
   logic     too_fast;
   logic     accept;

   assign wcfg     = lcd_cfg_t'(wdata);
   assign too_fast = frame_too_fast(wcfg, duty4,
                                    longint'(SUB_HZ), longint'(MAIN_HZ),
                                    longint'(MAX_FRAME_HZ),
                                    SRC_DIV_BASE, LCD_DIV_BASE);
   assign accept     = wr && !boost_on && !too_fast;
   assign cfg_change = accept && (wcfg != cfg);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg      <= '0;
         lock_err <= 1'b0;
         rate_err <= 1'b0;
      end else if (wr) begin
         if (boost_on) begin
            lock_err <= 1'b1;
         end else if (too_fast) begin
            rate_err <= 1'b1;
         end else begin
            cfg <= wcfg;
         end
      end
   end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_timing_pkg::*;
#(
   parameter int SUB_HZ       = 32768,
   parameter int MAIN_HZ      = 5000000,
   parameter int MAX_FRAME_HZ = 128,
   parameter int SRC_DIV_BASE = 5,
   parameter int LCD_DIV_BASE = 6,
   parameter int REG_W        = 8,
   parameter int IDX_W        = $clog2(DUTY_HI)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             boost_on,
   input  logic             main_ce,
   input  logic             sub_ce,
   input  logic             duty4,
   output logic             lcd_ce,
   output logic             frame_tick,
   output logic [IDX_W-1:0] com_idx,
   output logic             lock_err,
   output logic             rate_err
);
   generate
      if (REG_W < CFG_W) begin : g_bad_reg
         $error("lcd_timing_gen: REG_W narrower than the setting");
      end
      if (MAX_FRAME_HZ < 1 || SUB_HZ < 1 || MAIN_HZ < 1) begin : g_bad_hz
         $error("lcd_timing_gen: frequencies must be positive");
      end
   endgenerate

   lcd_cfg_t cfg;
   logic     cfg_change;
   logic     duty_q;
   logic     restart;
   logic     src_ce;

   lcd_cfg_reg #(
      .SUB_HZ       (SUB_HZ),
      .MAIN_HZ      (MAIN_HZ),
      .MAX_FRAME_HZ (MAX_FRAME_HZ),
      .SRC_DIV_BASE (SRC_DIV_BASE),
      .LCD_DIV_BASE (LCD_DIV_BASE)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .wdata      (reg_wdata[CFG_W-1:0]),
      .boost_on   (boost_on),
      .duty4      (duty4),
      .cfg        (cfg),
      .cfg_change (cfg_change),
      .lock_err   (lock_err),
      .rate_err   (rate_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_q <= 1'b0;
      end else begin
         duty_q <= duty4;
      end
   end

   assign restart = cfg_change || (duty4 != duty_q);

   lcd_src_sel #(
      .SRC_DIV_BASE (SRC_DIV_BASE),
      .SEL_W        (SEL_W)
   ) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .src_sel (cfg.src_sel),
      .main_ce (main_ce),
      .sub_ce  (sub_ce),
      .src_ce  (src_ce)
   );

   lcd_pow2_div #(
      .BASE  (LCD_DIV_BASE),
      .SEL_W (SEL_W)
   ) u_lcd_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .sel    (cfg.div_sel),
      .in_ce  (src_ce),
      .out_ce (lcd_ce)
   );

   lcd_frame_ctr #(
      .DUTY_A (DUTY_LO),
      .DUTY_B (DUTY_HI),
      .IDX_W  (IDX_W)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .duty_b  (duty_q),
      .step_ce (lcd_ce),
      .idx     (com_idx),
      .tick    (frame_tick)
   );

   assign reg_rdata = REG_W'(cfg);
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
   parameter int REG_W = 8,
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             boost_on,
   input logic             duty4,
   input logic             lcd_ce,
   input logic             frame_tick,
   input logic [IDX_W-1:0] com_idx,
   input logic             lock_err,
   input logic             rate_err
);
   // R4: a locked write changes nothing and raises the flag
   a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && boost_on |=> $stable(reg_rdata));
   a_r4_lock_flag: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && boost_on |=> lock_err);
   a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |=> lock_err);

   // R5: refused write keeps the setting, flag is sticky
   a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rate_err) |-> $past(reg_wr) && $stable(reg_rdata));
   a_r5_rate_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rate_err |=> rate_err);

   // R6: reserved write bits never reach the stored value
   a_r6_rsvd_drop: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && (reg_wdata[REG_W-1:4] != '0) |=> reg_rdata[REG_W-1:4] == '0);

   // R7: frame tick coincides with wrap, phase stays in range
   a_r7_tick_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |-> com_idx == '0);
   a_r7_tick_after_lcd: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |-> $past(lcd_ce));
   a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      !duty4 && $past(!duty4) |-> com_idx != IDX_W'(3));

   // R9: LCD pulses are single cycle
   a_r9_lcd_single: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_ce |=> !lcd_ce);
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(
   .REG_W (REG_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .boost_on   (boost_on),
   .duty4      (duty4),
   .lcd_ce     (lcd_ce),
   .frame_tick (frame_tick),
   .com_idx    (com_idx),
   .lock_err   (lock_err),
   .rate_err   (rate_err)
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
   localparam int SB   = 1;
   localparam int LB   = 1;
   localparam int SUBF = 1024;
   localparam int MAINF = 8192;
   localparam int MAXF = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       boost_on = 1'b0;
   logic       main_ce = 1'b0;
   logic       sub_ce = 1'b0;
   logic       duty4 = 1'b0;
   logic       lcd_ce;
   logic       frame_tick;
   logic [1:0] com_idx;
   logic       lock_err;
   logic       rate_err;

   lcd_timing_gen #(
      .SUB_HZ(SUBF), .MAIN_HZ(MAINF), .MAX_FRAME_HZ(MAXF),
      .SRC_DIV_BASE(SB), .LCD_DIV_BASE(LB)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .boost_on(boost_on), .main_ce(main_ce),
      .sub_ce(sub_ce), .duty4(duty4), .lcd_ce(lcd_ce), .frame_tick(frame_tick),
      .com_idx(com_idx), .lock_err(lock_err), .rate_err(rate_err)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int cyc = 0;

   int m_cfg = 0;
   bit m_d4 = 0;
   bit m_lock = 0;
   bit m_rate = 0;
   bit b_on = 0;
   bit b_duty = 0;
   int scnt = 0, lcnt = 0, mf = 0;
   bit hp0 = 0, hp1 = 0, fp0 = 0, fp1 = 0, fp2 = 0;
   int ip0 = 0, ip1 = 0, ip2 = 0;
   int mism = 0, n_lcd = 0, n_frm = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int divn(input int c);
      int n;
      n = 1 << (LB + (c & 3));
      if ((c >> 2) != 0) n = n << (SB + (c >> 2) - 1);
      return n;
   endfunction

   function automatic bit too_fast(input int c, input bit d4);
      longint src, lim;
      src = ((c >> 2) == 0) ? longint'(SUBF) : longint'(MAINF);
      lim = longint'(MAXF) * (d4 ? 4 : 3) * longint'(divn(c));
      if ((c >> 2) == 0) return src > lim;
      return src > lim;
   endfunction

   task automatic clear_model();
      scnt = 0; lcnt = 0;
      hp0 = 0; hp1 = 0; fp0 = 0; fp1 = 0; fp2 = 0;
      ip0 = 0; ip1 = 0; ip2 = 0;
   endtask

   task automatic step(input bit wr, input logic [7:0] wd, input bit ce_on);
      bit h, f, sel_pulse;
      @(negedge clk);
      if (lcd_ce !== hp1) mism++;
      if (frame_tick !== fp2) mism++;
      if (int'(com_idx) != ip2) mism++;
      if (lcd_ce === 1'b1) n_lcd++;
      if (frame_tick === 1'b1) n_frm++;
      reg_wr    = wr;
      reg_wdata = wd;
      boost_on  = b_on;
      duty4     = b_duty;
      main_ce   = ce_on && ((cyc % 4) != 3);
      sub_ce    = ce_on && ((cyc % 3) == 0);
      cyc++;
      h = 0; f = 0;
      sel_pulse = ((m_cfg >> 2) == 0) ? sub_ce : main_ce;
      if (sel_pulse) begin
         scnt++;
         if (scnt == divn(m_cfg)) begin
            scnt = 0; h = 1;
            lcnt = (lcnt + 1) % (m_d4 ? 4 : 3);
            f = (lcnt == 0);
            if (f) mf++;
         end
      end
      hp1 = hp0; hp0 = h;
      fp2 = fp1; fp1 = fp0; fp0 = f;
      ip2 = ip1; ip1 = ip0; ip0 = lcnt;
   endtask

   // Returns 1 when the write is expected to take effect.
   task automatic wr_cfg(input logic [7:0] wd, output bit took);
      int nc;
      bit rs;
      nc = int'(wd[3:0]);
      took = 0; rs = 0;
      if (b_on) m_lock = 1;
      else if (too_fast(nc, m_d4)) m_rate = 1;
      else begin
         took = 1;
         if (nc != m_cfg) begin m_cfg = nc; rs = 1; end
      end
      step(1, wd, 0);
      if (rs) clear_model();
      step(0, 8'h00, 0);
      chk(reg_rdata == 8'(m_cfg), $sformatf("R6 R4 R5 rdata after write %02h", wd),
          int'(reg_rdata), m_cfg);
      chk(lock_err == m_lock, "R4 lock flag", int'(lock_err), int'(m_lock));
      chk(rate_err == m_rate, $sformatf("R5 rate flag after write %02h", wd),
          int'(rate_err), int'(m_rate));
   endtask

   task automatic set_duty(input bit d);
      bit rs;
      rs = (d != m_d4);
      b_duty = d; m_d4 = d;
      step(0, 8'h00, 0);
      if (rs) clear_model();
   endtask

   task automatic run(input string tag);
      mism = 0; n_lcd = 0; n_frm = 0; mf = 0;
      while (mf < 2) step(0, 8'h00, 1);
      repeat (4) step(0, 8'h00, 0);
      chk(mism == 0, {"R2 R3 R7 R9 per-cycle ", tag}, mism, 0);
      chk(n_lcd == 2 * (m_d4 ? 4 : 3), {"R3 R7 lcd pulses ", tag}, n_lcd, 2 * (m_d4 ? 4 : 3));
      chk(n_frm == 2, {"R7 frames ", tag}, n_frm, 2);
   endtask

   initial begin
      bit took;
      repeat (5) @(negedge clk);
      chk(reg_rdata == 8'h00, "R1 rdata", int'(reg_rdata), 0);
      chk(lcd_ce == 1'b0 && frame_tick == 1'b0, "R1 pulses", int'({lcd_ce, frame_tick}), 0);
      chk(com_idx == 2'd0, "R1 com_idx", int'(com_idx), 0);
      chk(lock_err == 1'b0 && rate_err == 1'b0, "R1 flags", int'({lock_err, rate_err}), 0);
      rst_n = 1'b1;
      step(0, 8'h00, 0);
      for (int d = 0; d < 2; d++) begin
         set_duty(d[0]);
         for (int c = 0; c < 16; c++) begin
            wr_cfg({~c[3:0], c[3:0]}, took);
            if (took) run($sformatf("cfg %0d duty4 %0d", c, d));
         end
      end
      // R8: duty change while pulses are in flight
      wr_cfg(8'h05 | 8'h08, took);   // code 13: main /8 at base 1, lcd /4
      mism = 0;
      repeat (37) step(0, 8'h00, 1);
      set_duty(1'b0);
      chk(mism == 0, "R8 before restart", mism, 0);
      run("R8 after duty change");
      // R8: setting change mid-stream
      repeat (23) step(0, 8'h00, 1);
      wr_cfg(8'h0A, took);
      run("R8 after setting change");
      // R4: locked write ignored, timing undisturbed
      b_on = 1;
      step(0, 8'h00, 0);
      wr_cfg(8'h0F, took);
      run("R4 under lock");
      b_on = 0;
      step(0, 8'h00, 0);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule